// File: doc/BRIEF.md
# Calendar Timekeeper with Snapshot and Commit Handshake

This block keeps wall-clock time and calendar date in binary-coded decimal. It counts seconds, minutes, hours (24-hour), day of week, day of month, month and two-digit year. A slow oscillator enable (`tick_i`, nominally 32.768 kHz) is divided by a parameter to produce one advance per second. Each advance carries through the fields, with month lengths and a leap year rule applied.

Software never touches the running time directly. Readout goes through a holding bank that follows the running time until the read-freeze bit is raised. The holding bank then keeps the copy taken on the rising edge for as long as the bit stays high. Setting time goes through a separate staging bank. That bank can be written only while the write-lock bit is high, and the running time stays paused during that period. Lowering the lock bit loads the staging bank into the running time. A second that arrived during the lock is applied once, after the load.

Top module: `rtc_sync_core`

## Requirements
- R1: After reset, the time reads 00:00:00 with day-of-week 1, date 01, month 01 and year 00. The field selects are 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 date, 5 month and 6 year.
- R2: The running time advances by exactly one second for every `DIV` cycles in which `tick_i` is high.
- R3: Seconds and minutes roll over from BCD 59 to 00, and hours roll over from 23 to 00. Each rollover carries into the next field.
- R4: Day-of-week counts 1 to 7 and wraps from 7 to 1 at each midnight.
- R5: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and 29 for month 02 when the BCD year is divisible by 4, otherwise 28. The month wraps from 12 to 01 and carries into the year, which wraps from 99 to 00.
- R6: While `ctl_r_i` is low, `rd_data_o` shows the running time of the selected field. A 0-to-1 change of `ctl_r_i` captures the running time, and the readout stays frozen until `ctl_r_i` returns to 0.
- R7: When the rising edge of `ctl_r_i` falls in the same cycle as a second advance, the advanced time is captured.
- R8: The staging bank is written (`usr_sel_i` picks the field as in R1) only while `ctl_w_i` is high. A write while `ctl_w_i` is low is ignored.
- R9: A 1-to-0 change of `ctl_w_i` loads the entire staging bank into the running time.
- R10: While `ctl_w_i` is high, the running time does not advance. If one or more seconds occur during the lock, or a second occurs in the commit cycle, the loaded time is advanced by exactly one second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Oscillator enable, one pulse per timebase period |
| ctl_r_i | input | 1 | Read-freeze control bit |
| ctl_w_i | input | 1 | Write-lock / commit control bit |
| usr_we_i | input | 1 | Staging bank write strobe |
| usr_sel_i | input | 3 | Staging bank field select |
| usr_wdata_i | input | 8 | Staging bank write data (BCD) |
| rd_sel_i | input | 3 | Readout field select |
| rd_data_o | output | 8 | Selected field of the holding bank (BCD) |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a second advance and the read-freeze rising edge. The second pair is a second advance and the commit edge. The bench steps the oscillator phase until the divider is one tick from wrapping. It then raises the freeze bit, or drops the lock bit, in the very cycle that carries the final tick. For the freeze case, the captured readout must hold the advanced second, and it must not move over two more seconds. For the commit case, the running time must equal the staged value plus one second. A separate scenario lets several seconds pass during a lock and expects only a single added second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    localparam rtc_time_t RTC_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                        dow: 8'h01, date: 8'h01, mon: 8'h01,
                                        year: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [7:0] field_get(input rtc_time_t t, input logic [2:0] s);
        logic [7:0] r;
        case (s)
            3'd0:    r = t.sec;
            3'd1:    r = t.min;
            3'd2:    r = t.hour;
            3'd3:    r = t.dow;
            3'd4:    r = t.date;
            3'd5:    r = t.mon;
            3'd6:    r = t.year;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    function automatic rtc_time_t field_put(input rtc_time_t t, input logic [2:0] s,
                                            input logic [7:0] v);
        rtc_time_t r;
        r = t;
        case (s)
            3'd0:    r.sec  = v;
            3'd1:    r.min  = v;
            3'd2:    r.hour = v;
            3'd3:    r.dow  = v;
            3'd4:    r.date = v;
            3'd5:    r.mon  = v;
            3'd6:    r.year = v;
            default: r = t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic sec_pulse_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d       = cnt_q;
        sec_pulse_o = 1'b0;
        if (tick_i) begin
            if (cnt_q == LAST) begin
                cnt_d       = '0;
                sec_pulse_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_pulse_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse_o |-> tick_i);

endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur_i,
    output rtc_time_t nxt_o
);
    logic       c_min, c_hr, c_day, c_mon, c_yr, leap;
    logic [4:0] lsum;
    logic [7:0] mlen;

    always_comb begin
        lsum = {cur_i.year[7:4], 1'b0} + {1'b0, cur_i.year[3:0]};
        leap = (lsum[1:0] == 2'b00);
        case (cur_i.mon)
            8'h02:                      mlen = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: mlen = 8'h30;
            default:                    mlen = 8'h31;
        endcase

        nxt_o = cur_i;
        c_min = (cur_i.sec == 8'h59);
        c_hr  = c_min && (cur_i.min == 8'h59);
        c_day = c_hr && (cur_i.hour == 8'h23);
        c_mon = c_day && (cur_i.date == mlen);
        c_yr  = c_mon && (cur_i.mon == 8'h12);

        nxt_o.sec = c_min ? 8'h00 : bcd_inc(cur_i.sec);
        if (c_min) nxt_o.min  = c_hr ? 8'h00 : bcd_inc(cur_i.min);
        if (c_hr)  nxt_o.hour = c_day ? 8'h00 : bcd_inc(cur_i.hour);
        if (c_day) begin
            nxt_o.dow  = (cur_i.dow == 8'h07) ? 8'h01 : cur_i.dow + 8'h01;
            nxt_o.date = c_mon ? 8'h01 : bcd_inc(cur_i.date);
        end
        if (c_mon) nxt_o.mon  = c_yr ? 8'h01 : bcd_inc(cur_i.mon);
        if (c_yr)  nxt_o.year = (cur_i.year == 8'h99) ? 8'h00 : bcd_inc(cur_i.year);
    end

endmodule

// File: rtl/rtc_sync_core.sv
module rtc_sync_core
    import rtc_pkg::*;
#(
    parameter int DIV = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       ctl_r_i,
    input  logic       ctl_w_i,
    input  logic       usr_we_i,
    input  logic [2:0] usr_sel_i,
    input  logic [7:0] usr_wdata_i,
    input  logic [2:0] rd_sel_i,
    output logic [7:0] rd_data_o
);
    typedef struct packed {
        rtc_time_t core;
        rtc_time_t hold;
        rtc_time_t user;
        logic      w_q;
        logic      r_q;
        logic      pend;
    } st_t;

    st_t       st_d, st_q;
    logic      sec_pulse;
    logic      commit;
    rtc_time_t adv_in, adv_out;

    rtc_prescaler #(.DIV(DIV)) u_presc (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .sec_pulse_o (sec_pulse)
    );

    assign commit = st_q.w_q && !ctl_w_i;
    assign adv_in = commit ? st_q.user : st_q.core;

    rtc_advance u_adv (
        .cur_i (adv_in),
        .nxt_o (adv_out)
    );

    always_comb begin
        st_d = st_q;
        if (ctl_w_i) begin
            st_d.pend = st_q.pend | sec_pulse;
            if (usr_we_i) st_d.user = field_put(st_q.user, usr_sel_i, usr_wdata_i);
        end else if (commit) begin
            st_d.core = (st_q.pend || sec_pulse) ? adv_out : st_q.user;
            st_d.pend = 1'b0;
        end else if (sec_pulse) begin
            st_d.core = adv_out;
        end
        if (!ctl_r_i || !st_q.r_q) st_d.hold = st_d.core;
        st_d.w_q = ctl_w_i;
        st_d.r_q = ctl_r_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{core: RTC_RESET, hold: RTC_RESET, user: RTC_RESET,
                      w_q: 1'b0, r_q: 1'b0, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = field_get(st_q.hold, rd_sel_i);

    assert_lock_core_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_w_i |=> $stable(st_q.core));

    assert_pend_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.w_q && !ctl_w_i) |=> !st_q.pend);

    assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.r_q && ctl_r_i) |=> $stable(st_q.hold));

    assert_commit_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.w_q && !ctl_w_i && !st_q.pend && !sec_pulse) |=> (st_q.core == $past(st_q.user)));

    assert_user_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_w_i |=> $stable(st_q.user));

    assert_idle_no_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_w_i && !st_q.w_q && !sec_pulse) |=> $stable(st_q.core));

endmodule

// File: tb/rtc_sync_core_bench.sv
module rtc_sync_core_bench;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, ctl_r_i = 1'b0, ctl_w_i = 1'b0, usr_we_i = 1'b0;
    logic [2:0] usr_sel_i = '0, rd_sel_i = '0;
    logic [7:0] usr_wdata_i = '0;
    logic [7:0] rd_data_o;

    rtc_sync_core #(.DIV(DIV)) u_rtc_sync_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ctl_r_i(ctl_r_i),
        .ctl_w_i(ctl_w_i), .usr_we_i(usr_we_i), .usr_sel_i(usr_sel_i),
        .usr_wdata_i(usr_wdata_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o)
    );

    always #5 clk = ~clk;

    typedef struct { int sel; int exp; string tag; } item_t;
    item_t q[$];
    item_t it;
    int    tests = 0, fails = 0;
    bit    done = 0;
    int    m[7], snap[7], ub[7];
    int    ph = 0;
    bit    pend = 0, r_on = 0, w_on = 0;

    function automatic int to_bcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int mlen(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic madv();
        m[0]++;
        if (m[0] == 60) begin
            m[0] = 0; m[1]++;
            if (m[1] == 60) begin
                m[1] = 0; m[2]++;
                if (m[2] == 24) begin
                    m[2] = 0;
                    m[3] = (m[3] == 7) ? 1 : m[3] + 1;
                    m[4]++;
                    if (m[4] > mlen(m[5], m[6])) begin
                        m[4] = 1; m[5]++;
                        if (m[5] == 13) begin m[5] = 1; m[6] = (m[6] + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic model_tick();
        ph++;
        if (ph == DIV) begin
            ph = 0;
            if (w_on) pend = 1;
            else      madv();
        end
    endtask

    // Monitor: pops expected readouts and compares against the design
    always begin
        @(negedge clk);
        if (q.size() > 0) begin
            it = q.pop_front();
            rd_sel_i = it.sel[2:0];
            #1;
            tests++;
            if (rd_data_o !== it.exp[7:0]) begin
                fails++;
                $display("FAIL %s field %0d: actual %h expected %h", it.tag, it.sel, rd_data_o, it.exp[7:0]);
            end
        end
    end

    // Driver side: push the whole expected readout and wait for the monitor
    task automatic push_all(string tag);
        for (int i = 0; i < 7; i++) begin
            item_t e;
            e.sel = i;
            e.exp = to_bcd(r_on ? snap[i] : m[i]);
            e.tag = tag;
            q.push_back(e);
        end
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1; model_tick();
        end
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic to_next_second();
        ticks(DIV - ph);
    endtask

    task automatic lock();
        @(negedge clk); ctl_w_i = 1'b1; w_on = 1;
    endtask

    task automatic wr(int sel, int v);
        @(negedge clk); usr_we_i = 1'b1; usr_sel_i = sel[2:0]; usr_wdata_i = to_bcd(v)[7:0];
        if (w_on) ub[sel] = v;
        @(negedge clk); usr_we_i = 1'b0;
    endtask

    task automatic commit(bit with_tick);
        @(negedge clk); ctl_w_i = 1'b0; w_on = 0;
        if (with_tick) begin tick_i = 1'b1; ph++; if (ph == DIV) begin ph = 0; pend = 1; end end
        for (int i = 0; i < 7; i++) m[i] = ub[i];
        if (pend) madv();
        pend = 0;
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic set_all(int s, int mi, int h, int dw, int dt, int mo, int yr);
        lock();
        wr(0, s); wr(1, mi); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, yr);
        commit(0);
    endtask

    initial begin
        m = '{0, 0, 0, 1, 1, 1, 0};
        ub = m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push_all("R1 reset values");

        ticks(DIV);      push_all("R2 one second");
        ticks(DIV - 1);  push_all("R2 no early advance");
        ticks(1);        push_all("R2 second after full count");

        set_all(59, 59, 23, 7, 31, 12, 99); push_all("R9 commit load");
        to_next_second(); push_all("R3 R4 R5 year rollover");

        set_all(59, 59, 23, 3, 28, 2, 24); to_next_second(); push_all("R5 leap Feb 29");
        to_next_second(); push_all("R3 carry chain continues");
        set_all(59, 59, 23, 3, 28, 2, 23); to_next_second(); push_all("R5 common Feb to Mar");
        set_all(59, 59, 23, 5, 30, 4, 23); to_next_second(); push_all("R5 30-day month");
        set_all(59, 59, 23, 5, 31, 1, 23); to_next_second(); push_all("R5 31-day month");

        // R6 read freeze
        set_all(30, 20, 10, 2, 15, 6, 21);
        to_next_second(); push_all("R6 live readout");
        @(negedge clk); ctl_r_i = 1'b1; r_on = 1; snap = m;
        ticks(2 * DIV); push_all("R6 frozen readout");
        @(negedge clk); ctl_r_i = 1'b0; r_on = 0;
        @(negedge clk); push_all("R6 released readout");

        // R7 freeze rising together with a second advance
        ticks((DIV - 1 - ph + DIV) % DIV);
        @(negedge clk); tick_i = 1'b1; ctl_r_i = 1'b1; r_on = 1; model_tick(); snap = m;
        @(negedge clk); tick_i = 1'b0;
        push_all("R7 snapshot includes coincident second");
        ticks(2 * DIV); push_all("R7 snapshot held");
        @(negedge clk); ctl_r_i = 1'b0; r_on = 0;
        @(negedge clk); push_all("R7 live after release");

        // R10 pending seconds during lock
        lock();
        ticks(DIV); ticks(DIV);
        push_all("R10 frozen while locked");
        wr(0, 0); wr(1, 0); wr(2, 12);
        commit(0); push_all("R10 single pending second applied");

        // R8 writes while unlocked are ignored
        wr(0, 33);
        lock(); commit(0); push_all("R8 unlocked write ignored");

        // R9 exact load without pending second
        lock(); wr(0, 45); commit(0); push_all("R9 exact load");

        // R10 commit coincident with a second advance
        ticks((DIV - 1 - ph + DIV) % DIV);
        lock(); wr(0, 10); wr(1, 40);
        commit(1); push_all("R10 commit coincident second");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule